// File: doc/BRIEF.md
# Predicated issue gating unit

This block holds the five one-bit condition flags of a wide-issue core and decides, for every instruction of an execute packet, whether that instruction may commit or has to be squashed. Compare units write a true or false outcome into a chosen flag. Every instruction carries a predicate field made of a 3-bit flag selector and an invert bit. A squashed instruction still moves down the pipeline, but its commit enable is low, so its register writes and side effects are dropped.

Up to eight predicate fields are looked up in parallel against the stored flags. Each packet slot gets a commit enable and an illegal-selector indication. Flag writes arrive on a small number of write ports. A write becomes visible to lookups in the following cycle. Lookups are combinational from the stored flags, and the only state in the block is the flag file.

Top module: `pred_gate`

## Requirements
- R1: After reset all five flags read as zero. A valid slot that selects a flag is therefore squashed when its invert bit is 0 and commits when its invert bit is 1.
- R2: A valid slot with selector 000 commits, whatever its invert bit.
- R3: Selectors 001 to 101 pick flags 1 to 5. A valid slot with invert bit 0 commits exactly when the selected flag is 1.
- R4: A valid slot with invert bit 1 commits exactly when the selected flag is 0.
- R5: Two valid slots in the same packet that name the same flag with opposite invert bits never commit together, and never both squash.
- R6: Selectors 110 and 111 are treated as unconditional. The slot commits and its illegal_pred bit is 1. illegal_pred is 0 for every other selector.
- R7: A slot whose valid bit is 0 drives commit_en and illegal_pred low.
- R8: A flag write made in cycle N is seen by lookups from cycle N+1 on. Lookups in cycle N still see the old value.
- R9: A flag write whose selector is 000, 110 or 111 changes no flag.
- R10: When several write ports target the same flag in one cycle, the highest-numbered port wins.
- R11: A flag keeps its value in every cycle in which no write port targets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | WR_PORTS | Per-port flag write enable |
| wr_sel | input | WR_PORTS*3 | Per-port flag selector, port p at bits [3p+2:3p] |
| wr_val | input | WR_PORTS | Per-port compare outcome to store |
| slot_valid | input | SLOTS | Slot holds an instruction |
| slot_sel | input | SLOTS*3 | Per-slot predicate selector, slot s at bits [3s+2:3s] |
| slot_inv | input | SLOTS | Per-slot invert bit (1 = run when the flag is zero) |
| commit_en | output | SLOTS | Per-slot commit enable |
| illegal_pred | output | SLOTS | Per-slot unmapped-selector indication |

## Verification
The hardest cases to reach are the timing boundary and the write conflict. A flag written in the same cycle as a lookup must still show its old value, and two ports writing one flag must leave the value from the higher port. The bench drives a write and a lookup of the same flag in one cycle and checks both sides of the clock edge. It also issues conflicting writes in both value orders. All 32 flag patterns are loaded, and each is followed by sweeps over every selector and invert pair under changing valid masks, opposite-sense pairs, idle cycles for retention, and writes to unmapped selectors.

// File: rtl/pred_gate_pkg.sv
`timescale 1ns/1ps
package pred_gate_pkg;
    localparam int SEL_W = 3;
    localparam int NCOND = 5;

    typedef logic [SEL_W-1:0] psel_t;

    typedef struct packed {
        logic [NCOND-1:0] flag;
    } cond_state_t;

    typedef struct packed {
        logic hit;
        logic bit_val;
    } lookup_t;

    // Map a selector onto the flag file; hit is low for 000 and unmapped codes.
    function automatic lookup_t cond_lookup(input psel_t sel, input logic [NCOND-1:0] flags);
        lookup_t r;
        r = '0;
        for (int k = 0; k < NCOND; k++) begin
            if (sel == psel_t'(k + 1)) begin
                r.hit     = 1'b1;
                r.bit_val = flags[k];
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/pred_gate_cfile.sv
`timescale 1ns/1ps
module pred_gate_cfile
    import pred_gate_pkg::*;
#(
    parameter int WR_PORTS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WR_PORTS-1:0]       wr_en,
    input  logic [WR_PORTS*SEL_W-1:0] wr_sel,
    input  logic [WR_PORTS-1:0]       wr_val,
    output logic [NCOND-1:0]          flags
);
    cond_state_t st_d, st_q;

    // Later ports are applied last, so the highest port wins a conflict.
    always_comb begin
        st_d = st_q;
        for (int p = 0; p < WR_PORTS; p++) begin
            for (int k = 0; k < NCOND; k++) begin
                if (wr_en[p] && (wr_sel[p*SEL_W +: SEL_W] == psel_t'(k + 1))) begin
                    st_d.flag[k] = wr_val[p];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;
endmodule

// File: rtl/pred_gate_slot.sv
`timescale 1ns/1ps
module pred_gate_slot
    import pred_gate_pkg::*;
(
    input  logic             valid,
    input  psel_t            sel,
    input  logic             inv,
    input  logic [NCOND-1:0] flags,
    output logic             commit,
    output logic             illegal
);
    lookup_t lk;

    always_comb begin
        lk      = cond_lookup(sel, flags);
        commit  = valid & (lk.hit ? (lk.bit_val ^ inv) : 1'b1);
        illegal = valid & ~lk.hit & (sel != '0);
    end
endmodule

// File: rtl/pred_gate.sv
`timescale 1ns/1ps
module pred_gate
    import pred_gate_pkg::*;
#(
    parameter int SLOTS    = 8,
    parameter int WR_PORTS = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [WR_PORTS-1:0]       wr_en,
    input  logic [WR_PORTS*SEL_W-1:0] wr_sel,
    input  logic [WR_PORTS-1:0]       wr_val,
    input  logic [SLOTS-1:0]          slot_valid,
    input  logic [SLOTS*SEL_W-1:0]    slot_sel,
    input  logic [SLOTS-1:0]          slot_inv,
    output logic [SLOTS-1:0]          commit_en,
    output logic [SLOTS-1:0]          illegal_pred
);
    logic [NCOND-1:0] flags;

    pred_gate_cfile #(.WR_PORTS(WR_PORTS)) u_cfile (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (wr_sel),
        .wr_val (wr_val),
        .flags  (flags)
    );

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        pred_gate_slot u_slot (
            .valid   (slot_valid[g]),
            .sel     (slot_sel[g*SEL_W +: SEL_W]),
            .inv     (slot_inv[g]),
            .flags   (flags),
            .commit  (commit_en[g]),
            .illegal (illegal_pred[g])
        );
    end
endmodule

// File: rtl/pred_gate_chk.sv
`timescale 1ns/1ps
module pred_gate_chk
    import pred_gate_pkg::*;
#(
    parameter int SLOTS    = 8,
    parameter int WR_PORTS = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [WR_PORTS-1:0]       wr_en,
    input logic [WR_PORTS*SEL_W-1:0] wr_sel,
    input logic [WR_PORTS-1:0]       wr_val,
    input logic [SLOTS-1:0]          slot_valid,
    input logic [SLOTS*SEL_W-1:0]    slot_sel,
    input logic [SLOTS-1:0]          slot_inv,
    input logic [SLOTS-1:0]          commit_en,
    input logic [SLOTS-1:0]          illegal_pred
);
    localparam int TP = WR_PORTS - 1;

    psel_t ssel [SLOTS];
    psel_t top_sel;
    assign top_sel = wr_sel[TP*SEL_W +: SEL_W];

    for (genvar i = 0; i < SLOTS; i++) begin : g_one
        assign ssel[i] = slot_sel[i*SEL_W +: SEL_W];

        a_r2_uncond_commits: assert property (@(posedge clk) disable iff (!rst_n)
            (slot_valid[i] && ssel[i] == '0) |-> commit_en[i]);

        a_r6_illegal_commits: assert property (@(posedge clk) disable iff (!rst_n)
            illegal_pred[i] |-> (commit_en[i] && slot_valid[i] && ssel[i] > psel_t'(NCOND)));

        a_r7_invalid_quiet: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_valid[i] |-> (!commit_en[i] && !illegal_pred[i]));

        for (genvar j = i + 1; j < SLOTS; j++) begin : g_pair
            a_r5_opposite_one: assert property (@(posedge clk) disable iff (!rst_n)
                (slot_valid[i] && slot_valid[j] && ssel[i] == ssel[j] &&
                 ssel[i] != '0 && ssel[i] <= psel_t'(NCOND) && slot_inv[i] != slot_inv[j])
                |-> (commit_en[i] != commit_en[j]));
        end
    end

    // R8 and R10: the highest port's value is what slot 0 sees one cycle later.
    a_r8_next_cycle_value: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en[TP] && top_sel != '0 && top_sel <= psel_t'(NCOND))
        |=> (!(slot_valid[0] && !slot_inv[0] && ssel[0] == $past(top_sel)) ||
             (commit_en[0] == $past(wr_val[TP]))));

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en) == '0 && slot_valid[0] && $past(slot_valid[0]) &&
         $stable(ssel[0]) && $stable(slot_inv[0])) |-> $stable(commit_en[0]));
endmodule

bind pred_gate pred_gate_chk #(.SLOTS(SLOTS), .WR_PORTS(WR_PORTS)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_sel       (wr_sel),
    .wr_val       (wr_val),
    .slot_valid   (slot_valid),
    .slot_sel     (slot_sel),
    .slot_inv     (slot_inv),
    .commit_en    (commit_en),
    .illegal_pred (illegal_pred)
);

// File: tb/pred_gate_bench.sv
`timescale 1ns/1ps
module pred_gate_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wr_en = '0;
    logic [5:0]  wr_sel = '0;
    logic [1:0]  wr_val = '0;
    logic [7:0]  slot_valid = '0;
    logic [23:0] slot_sel = '0;
    logic [7:0]  slot_inv = '0;
    logic [7:0]  commit_en;
    logic [7:0]  illegal_pred;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 1'b0;
    logic [5:0] m = '0;   // expected flags, index 1..5

    always #2.5 clk = ~clk;

    pred_gate #(.SLOTS(8), .WR_PORTS(2)) u_pred_gate (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_val(wr_val),
        .slot_valid(slot_valid), .slot_sel(slot_sel), .slot_inv(slot_inv),
        .commit_en(commit_en), .illegal_pred(illegal_pred)
    );

    function automatic bit exp_c(bit v, logic [2:0] s, bit inv);
        if (!v) return 1'b0;
        if (s == 3'd0 || s > 3'd5) return 1'b1;
        return m[s] ^ inv;
    endfunction

    function automatic string tag_of(bit v, logic [2:0] s, bit inv);
        if (!v) return "R7";
        if (s == 3'd0) return "R2";
        if (s > 3'd5) return "R6";
        if (inv) return "R4";
        return "R3";
    endfunction

    task automatic check(string req, int slot, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s slot %0d %s actual=%b expected=%b", req, slot, what, act, exp);
        end
    endtask

    task automatic cyc_write(bit e0, logic [2:0] s0, bit v0, bit e1, logic [2:0] s1, bit v1);
        @(negedge clk);
        slot_valid = '0;
        wr_en  = {e1, e0};
        wr_sel = {s1, s0};
        wr_val = {v1, v0};
        @(posedge clk);
        if (e0 && s0 >= 3'd1 && s0 <= 3'd5) m[s0] = v0;
        if (e1 && s1 >= 3'd1 && s1 <= 3'd5) m[s1] = v1;
    endtask

    task automatic eval_combo(logic [7:0] v, int base, string phase);
        @(negedge clk);
        wr_en = '0;
        slot_valid = v;
        for (int k = 0; k < 8; k++) begin
            slot_sel[k*3 +: 3] = 3'(((base + k) % 16) >> 1);
            slot_inv[k]        = 1'(((base + k) % 16) & 1);
        end
        #1;
        for (int k = 0; k < 8; k++) begin
            check({phase, tag_of(v[k], slot_sel[k*3 +: 3], slot_inv[k])}, k, commit_en[k],
                  exp_c(v[k], slot_sel[k*3 +: 3], slot_inv[k]), "commit");
            check({phase, (!v[k]) ? "R7" : "R6"}, k, illegal_pred[k],
                  v[k] && (slot_sel[k*3 +: 3] > 3'd5), "illegal");
        end
    endtask

    task automatic eval_pairs();
        @(negedge clk);
        wr_en = '0;
        slot_valid = 8'hFF;
        for (int k = 0; k < 4; k++) begin
            slot_sel[(2*k)*3 +: 3]   = (k == 3) ? 3'd5 : 3'(k + 1);
            slot_sel[(2*k+1)*3 +: 3] = (k == 3) ? 3'd5 : 3'(k + 1);
            slot_inv[2*k]   = 1'b0;
            slot_inv[2*k+1] = 1'b1;
        end
        #1;
        for (int k = 0; k < 4; k++) begin
            check("R5", 2*k, commit_en[2*k] ^ commit_en[2*k+1], 1'b1, "exactly one of pair");
            check("R5", 2*k, commit_en[2*k], m[slot_sel[(2*k)*3 +: 3]], "pair plain sense");
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m = '0;
        eval_combo(8'hFF, 0, "R1/");
        eval_combo(8'hFF, 8, "R1/");

        // writes to selectors 000, 110, 111 leave every flag at zero
        cyc_write(1'b1, 3'd0, 1'b1, 1'b1, 3'd6, 1'b1);
        cyc_write(1'b1, 3'd7, 1'b1, 1'b0, 3'd0, 1'b0);
        eval_combo(8'hFF, 0, "R9/");
        eval_combo(8'hFF, 8, "R9/");

        for (int pat = 0; pat < 32; pat++) begin
            logic [7:0] v1, v2;
            v1 = ~8'(pat * 13);
            v2 = 8'(pat * 29 + 3);
            cyc_write(1'b1, 3'd1, pat[0], 1'b1, 3'd2, pat[1]);
            cyc_write(1'b1, 3'd3, pat[2], 1'b1, 3'd4, pat[3]);
            cyc_write(1'b1, 3'd5, pat[4], 1'b1, pat[0] ? 3'd6 : 3'd7, 1'b1);
            eval_combo(v1, 0, "");
            eval_combo(v2, 8, "");
            eval_combo(~v1, 0, "");
            eval_combo(~v2, 8, "");
            @(negedge clk);
            slot_valid = '0;
            @(negedge clk);
            eval_combo(v1 | 8'h0F, 0, "R11/");
            eval_pairs();
        end

        // R10: both ports target flag 3; port 1 must win in either value order
        cyc_write(1'b1, 3'd3, 1'b1, 1'b1, 3'd3, 1'b0);
        eval_combo(8'hFF, 0, "R10/");
        cyc_write(1'b1, 3'd3, 1'b0, 1'b1, 3'd3, 1'b1);
        eval_combo(8'hFF, 0, "R10/");

        // R8: write and lookup of flag 2 in the same cycle
        for (int rep = 0; rep < 2; rep++) begin
            @(negedge clk);
            wr_en  = 2'b01;
            wr_sel = {3'd0, 3'd2};
            wr_val = {1'b0, ~m[2]};
            slot_valid = 8'h01;
            slot_sel[2:0] = 3'd2;
            slot_inv[0] = 1'b0;
            #1;
            check("R8", 0, commit_en[0], m[2], "same-cycle old value");
            @(posedge clk);
            m[2] = ~m[2];
            @(negedge clk);
            wr_en = '0;
            #1;
            check("R8", 0, commit_en[0], m[2], "next-cycle new value");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule